// File: doc/BRIEF.md
# Frame Readback ECC Scrubber

This block keeps a memory organised as fixed-size frames free of single-bit upsets. Each frame holds WORDS data words of DATA_W bits (41 × 32 by default, 1312 data bits) and a stored 12-bit check code. The block reads every frame in turn, one word per cycle, and accumulates a position code and a parity bit over the data. At the end of each frame it combines them with the stored code to form a syndrome.

A zero syndrome lets the scan move straight on to the next frame. A syndrome that names a single flipped data bit starts a repair phase. The scrubber reads the affected word, inverts that bit and writes the word back in the same cycle. It then reads the whole frame a second time, and only a clean result on that second read counts as a repaired frame. Any syndrome that cannot be corrected sets a sticky flag, and nothing is written. Every non-zero syndrome is reported together with its frame address.

The memory port reads combinationally: `mem_rdata` and `mem_ecc` must reflect `mem_frame`/`mem_word` within the same cycle. DATA_W must be a power of two.

Top module: `scrub_frame_ecc`

## Requirements
- R1: While reset is held and just after it, `mem_we`, `fixed_count`, `uncorrectable`, `mem_frame`, `mem_word` and `err_syndrome` are all zero.
- R2: With `scrub_en` high, the block reads words 0 to WORDS-1 of a frame on consecutive cycles. One evaluation cycle follows with `mem_word` = 0. The scan then moves to the next frame, and after frame FRAMES-1 it wraps to frame 0.
- R3: Data bit k of a frame (k = word*DATA_W + bit) has position code k+1. The stored code is {parity of all data bits, XOR of the position codes of all set bits}, with parity in bit 11. The syndrome is the stored code XOR the same quantity recomputed from the read-back data.
- R4: A frame with a zero syndrome causes no write, and it leaves `err_frame`, `err_syndrome` and `fixed_count` unchanged.
- R5: A syndrome with parity bit 1 and position p in 1..1312 leads to exactly one write. The write goes to word (p-1)/32 of the same frame, and its data equals the read data with bit (p-1)%32 inverted.
- R6: After a write, the same frame is read again. A zero syndrome on that re-read increments `fixed_count` by one. A non-zero syndrome sets `uncorrectable` and leaves the count unchanged.
- R7: On every non-zero syndrome, `err_frame` and `err_syndrome` are loaded with the frame address and the syndrome.
- R8: A non-zero position with parity bit 0 (a double error) sets `uncorrectable` and causes no write.
- R9: A position above 1312 with parity 1, or a zero position with parity 1, sets `uncorrectable` and causes no write.
- R10: Once set, `uncorrectable` stays set until reset.
- R11: When `scrub_en` goes low, the block finishes the frame in progress and then idles. While idle, `mem_word` stays 0, `mem_frame` stays fixed, nothing is written and errors in memory are left alone. Raising `scrub_en` again resumes the scan.
- R12: `mem_we` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scrub_en | input | 1 | Enables continuous scanning |
| mem_frame | output | 2 | Frame address of the current access |
| mem_word | output | 6 | Word index of the current access |
| mem_rdata | input | 32 | Word read from the addressed location (combinational) |
| mem_ecc | input | 12 | Stored check code of the addressed frame |
| mem_wdata | output | 32 | Repaired word to write |
| mem_we | output | 1 | Write strobe for the repaired word |
| err_frame | output | 2 | Frame of the last non-zero syndrome |
| err_syndrome | output | 12 | Last non-zero syndrome {parity, position} |
| fixed_count | output | 16 | Saturating count of confirmed repairs |
| uncorrectable | output | 1 | Sticky flag for errors that cannot be repaired |

## Verification
The bound checker checks on every cycle that addresses stay in range and that each write flips exactly one bit relative to the read data. It also checks that a write is a one-cycle pulse to an unchanged frame, that the repair count only steps by one, and that the uncorrectable flag never clears. Other behaviour needs the bench's directed scenarios. These cover the exact scan order and wrap, the choice of word and bit from a given syndrome, and the reported frame and syndrome values. They also cover the double-error, out-of-range and parity-only verdicts, a memory that drops writes so the re-read fails, and idling with an error left in place.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_EVAL,
    ST_FIX
  } scrub_state_e;

  typedef enum logic [1:0] {
    VD_CLEAN,
    VD_FIX,
    VD_BAD
  } verdict_e;

endpackage

// File: rtl/scrub_rst_sync.sv
module scrub_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= 2'b00;
    else        pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_sync_n = pipe_q[1];
endmodule

// File: rtl/scrub_syn_acc.sv
module scrub_syn_acc #(
  parameter int DATA_W = 32,
  parameter int WIX_W  = 6,
  parameter int POS_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              acc_en,
  input  logic [WIX_W-1:0]  word_idx,
  input  logic [DATA_W-1:0] rdata,
  output logic [POS_W-1:0]  pos_acc,
  output logic              par_acc
);
  logic [POS_W-1:0] pos_n;
  logic             par_n;

  function automatic logic [POS_W-1:0] word_code(input logic [DATA_W-1:0] d,
                                                 input logic [WIX_W-1:0] w);
    logic [POS_W-1:0] c;
    c = '0;
    for (int b = 0; b < DATA_W; b++) begin
      if (d[b]) c = c ^ POS_W'(int'(w) * DATA_W + b + 1);
    end
    return c;
  endfunction

  always_comb begin
    pos_n = pos_acc;
    par_n = par_acc;
    if (clr) begin
      pos_n = '0;
      par_n = 1'b0;
    end else if (acc_en) begin
      pos_n = pos_acc ^ word_code(rdata, word_idx);
      par_n = par_acc ^ (^rdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_acc <= '0;
      par_acc <= 1'b0;
    end else if (clr || acc_en) begin
      pos_acc <= pos_n;
      par_acc <= par_n;
    end
  end
endmodule

// File: rtl/scrub_classify.sv
module scrub_classify
  import scrub_pkg::*;
#(
  parameter int POS_W = 11,
  parameter int BITS  = 1312
) (
  input  logic [POS_W-1:0] pos_acc,
  input  logic             par_acc,
  input  logic [POS_W:0]   stored,
  output logic [POS_W:0]   syndrome,
  output verdict_e         verdict
);
  logic [POS_W-1:0] pos;
  logic             par;

  assign pos      = pos_acc ^ stored[POS_W-1:0];
  assign par      = par_acc ^ stored[POS_W];
  assign syndrome = {par, pos};

  always_comb begin
    if (!par && pos == '0)
      verdict = VD_CLEAN;
    else if (par && pos != '0 && pos <= POS_W'(BITS))
      verdict = VD_FIX;
    else
      verdict = VD_BAD;
  end
endmodule

// File: rtl/scrub_frame_ecc.sv
module scrub_frame_ecc
  import scrub_pkg::*;
#(
  parameter int FRAMES = 4,
  parameter int WORDS  = 41,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              scrub_en,
  output logic [$clog2(FRAMES)-1:0]         mem_frame,
  output logic [$clog2(WORDS)-1:0]          mem_word,
  input  logic [DATA_W-1:0]                 mem_rdata,
  input  logic [$clog2(WORDS*DATA_W+1):0]   mem_ecc,
  output logic [DATA_W-1:0]                 mem_wdata,
  output logic                              mem_we,
  output logic [$clog2(FRAMES)-1:0]         err_frame,
  output logic [$clog2(WORDS*DATA_W+1):0]   err_syndrome,
  output logic [CNT_W-1:0]                  fixed_count,
  output logic                              uncorrectable
);
  localparam int FA_W  = $clog2(FRAMES);
  localparam int WIX_W = $clog2(WORDS);
  localparam int BITS  = WORDS * DATA_W;
  localparam int POS_W = $clog2(BITS + 1);
  localparam int ECC_W = POS_W + 1;
  localparam int BIX_W = $clog2(DATA_W);

  logic rst_i_n;
  scrub_state_e state_q, state_n;
  logic [FA_W-1:0]  frame_q, frame_n;
  logic [WIX_W-1:0] word_q, word_n;
  logic             verify_q, verify_n;
  logic [BIX_W-1:0] fbit_q, fbit_n;
  logic [FA_W-1:0]  efr_q, efr_n;
  logic [ECC_W-1:0] esyn_q, esyn_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             unc_q, unc_n;

  logic [POS_W-1:0] pos_acc;
  logic             par_acc;
  logic [ECC_W-1:0] syndrome;
  verdict_e         verdict;
  logic [POS_W-1:0] bitpos;
  logic             advance;

  scrub_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  scrub_syn_acc #(.DATA_W(DATA_W), .WIX_W(WIX_W), .POS_W(POS_W)) u_acc (
    .clk(clk), .rst_n(rst_i_n),
    .clr(state_q != ST_SCAN), .acc_en(state_q == ST_SCAN),
    .word_idx(word_q), .rdata(mem_rdata),
    .pos_acc(pos_acc), .par_acc(par_acc)
  );

  scrub_classify #(.POS_W(POS_W), .BITS(BITS)) u_cls (
    .pos_acc(pos_acc), .par_acc(par_acc), .stored(mem_ecc),
    .syndrome(syndrome), .verdict(verdict)
  );

  assign bitpos = syndrome[POS_W-1:0] - 1'b1;

  always_comb begin
    state_n  = state_q;
    frame_n  = frame_q;
    word_n   = word_q;
    verify_n = verify_q;
    fbit_n   = fbit_q;
    efr_n    = efr_q;
    esyn_n   = esyn_q;
    cnt_n    = cnt_q;
    unc_n    = unc_q;
    advance  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        word_n = '0;
        if (scrub_en) state_n = ST_SCAN;
      end
      ST_SCAN: begin
        if (word_q == WIX_W'(WORDS - 1)) begin
          word_n  = '0;
          state_n = ST_EVAL;
        end else begin
          word_n = word_q + 1'b1;
        end
      end
      ST_EVAL: begin
        if (verdict != VD_CLEAN) begin
          efr_n  = frame_q;
          esyn_n = syndrome;
        end
        if (verdict == VD_CLEAN) begin
          if (verify_q && cnt_q != '1) cnt_n = cnt_q + 1'b1;
          advance = 1'b1;
        end else if (verdict == VD_FIX && !verify_q) begin
          word_n  = WIX_W'(bitpos >> BIX_W);
          fbit_n  = bitpos[BIX_W-1:0];
          state_n = ST_FIX;
        end else begin
          unc_n   = 1'b1;
          advance = 1'b1;
        end
        if (advance) begin
          verify_n = 1'b0;
          frame_n  = (frame_q == FA_W'(FRAMES - 1)) ? '0 : frame_q + 1'b1;
          state_n  = scrub_en ? ST_SCAN : ST_IDLE;
        end
      end
      ST_FIX: begin
        verify_n = 1'b1;
        word_n   = '0;
        state_n  = ST_SCAN;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q  <= ST_IDLE;
      frame_q  <= '0;
      word_q   <= '0;
      verify_q <= 1'b0;
      fbit_q   <= '0;
      efr_q    <= '0;
      esyn_q   <= '0;
      cnt_q    <= '0;
      unc_q    <= 1'b0;
    end else begin
      state_q  <= state_n;
      frame_q  <= frame_n;
      word_q   <= word_n;
      verify_q <= verify_n;
      fbit_q   <= fbit_n;
      efr_q    <= efr_n;
      esyn_q   <= esyn_n;
      cnt_q    <= cnt_n;
      unc_q    <= unc_n;
    end
  end

  assign mem_frame     = frame_q;
  assign mem_word      = word_q;
  assign mem_we        = (state_q == ST_FIX);
  assign mem_wdata     = mem_rdata ^ (DATA_W'(1) << fbit_q);
  assign err_frame     = efr_q;
  assign err_syndrome  = esyn_q;
  assign fixed_count   = cnt_q;
  assign uncorrectable = unc_q;
endmodule

// File: rtl/scrub_frame_ecc_chk.sv
module scrub_frame_ecc_chk #(
  parameter int FRAMES = 4,
  parameter int WORDS  = 41,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int FA_W   = 2,
  parameter int WIX_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FA_W-1:0]   mem_frame,
  input logic [WIX_W-1:0]  mem_word,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic [CNT_W-1:0]  fixed_count,
  input logic              uncorrectable
);
  p_word_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mem_word) < WORDS);

  p_frame_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mem_frame) < FRAMES);

  p_one_bit_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $countones(mem_wdata ^ mem_rdata) == 1);

  p_write_same_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $stable(mem_frame));

  p_we_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_count != $past(fixed_count)) |-> (fixed_count == $past(fixed_count) + CNT_W'(1)));

  p_unc_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(uncorrectable) |-> uncorrectable);
endmodule

bind scrub_frame_ecc scrub_frame_ecc_chk #(
  .FRAMES(FRAMES), .WORDS(WORDS), .DATA_W(DATA_W), .CNT_W(CNT_W),
  .FA_W(FA_W), .WIX_W(WIX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_frame(mem_frame), .mem_word(mem_word),
  .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
  .fixed_count(fixed_count), .uncorrectable(uncorrectable)
);

// File: tb/scrub_frame_ecc_test.sv
module scrub_frame_ecc_test;
  localparam int FRAMES = 4;
  localparam int WORDS  = 41;
  localparam int PASS_CYC = FRAMES * (WORDS + 1);

  logic        clk;
  logic        rst_n;
  logic        scrub_en;
  logic [1:0]  mem_frame;
  logic [5:0]  mem_word;
  logic [31:0] mem_rdata;
  logic [11:0] mem_ecc;
  logic [31:0] mem_wdata;
  logic        mem_we;
  logic [1:0]  err_frame;
  logic [11:0] err_syndrome;
  logic [15:0] fixed_count;
  logic        uncorrectable;

  logic [31:0] fmem [FRAMES][WORDS];
  logic [11:0] fecc [FRAMES];
  bit          stuck;
  int          we_cnt;
  int          checks;
  int          fails;

  scrub_frame_ecc uut (
    .clk(clk), .rst_n(rst_n), .scrub_en(scrub_en),
    .mem_frame(mem_frame), .mem_word(mem_word), .mem_rdata(mem_rdata),
    .mem_ecc(mem_ecc), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .err_frame(err_frame), .err_syndrome(err_syndrome),
    .fixed_count(fixed_count), .uncorrectable(uncorrectable)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign mem_rdata = fmem[mem_frame][mem_word];
  assign mem_ecc   = fecc[mem_frame];

  always @(posedge clk) begin
    if (mem_we) begin
      we_cnt = we_cnt + 1;
      if (!stuck) fmem[mem_frame][mem_word] <= mem_wdata;
    end
  end

  function automatic logic [11:0] calc_code(input int f);
    logic [10:0] p;
    logic        q;
    p = '0;
    q = 1'b0;
    for (int w = 0; w < WORDS; w++)
      for (int b = 0; b < 32; b++)
        if (fmem[f][w][b]) begin
          p = p ^ 11'(w * 32 + b + 1);
          q = ~q;
        end
    return {q, p};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    scrub_en = 1'b0;
    stuck    = 1'b0;
    for (int f = 0; f < FRAMES; f++) begin
      for (int w = 0; w < WORDS; w++)
        fmem[f][w] = 32'h5A3C_0F96 ^ ((f * 977 + w * 131 + 7) * 32'h9E37_79B1);
      fecc[f] = calc_code(f);
    end
    step(3);
    rst_n = 1'b1;
    step(4);
    we_cnt = 0;
  endtask

  task automatic flip(input int f, input int w, input int b);
    fmem[f][w][b] = ~fmem[f][w][b];
  endtask

  task automatic wait_for_count(input int n, input int maxc);
    for (int i = 0; i < maxc && int'(fixed_count) < n; i++) step(1);
  endtask

  task automatic wait_for_unc(input int maxc);
    for (int i = 0; i < maxc && !uncorrectable; i++) step(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(2);
    check(mem_we == 1'b0 && fixed_count == 0 && uncorrectable == 1'b0,
          "R1 strobe/count/flag in reset", {mem_we, fixed_count, uncorrectable}, 0);
    check(mem_frame == 0 && mem_word == 0 && err_syndrome == 0,
          "R1 address/syndrome in reset", {mem_frame, mem_word, err_syndrome}, 0);
    do_reset();
    check(mem_we == 1'b0 && fixed_count == 0 && mem_frame == 0 && mem_word == 0,
          "R1 state after release", {mem_we, fixed_count, mem_frame, mem_word}, 0);
  endtask

  task automatic t_scan_order();
    bit ok;
    do_reset();
    scrub_en = 1'b1;
    step(1);
    for (int k = 0; k < FRAMES + 2; k++) begin
      ok = 1'b1;
      for (int w = 0; w < WORDS; w++) begin
        if (mem_frame != 2'(k % FRAMES) || int'(mem_word) != w) begin
          ok = 1'b0;
          check(1'b0, "R2 scan word", {mem_frame, mem_word}, {2'(k % FRAMES), 6'(w)});
        end
        step(1);
      end
      check(ok && mem_word == 0 && mem_frame == 2'(k % FRAMES) && !mem_we,
            "R2 frame scan and evaluation cycle", {mem_frame, mem_word}, {2'(k % FRAMES), 6'd0});
      step(1);
    end
    check(we_cnt == 0 && fixed_count == 0 && err_syndrome == 0,
          "R4 clean frames leave no trace", we_cnt, 0);
  endtask

  task automatic t_single();
    logic [11:0] exp_syn;
    logic [31:0] good;
    int i;
    do_reset();
    good = fmem[2][17];
    flip(2, 17, 5);
    exp_syn = calc_code(2) ^ fecc[2];
    check(exp_syn == {1'b1, 11'd550}, "R3 syndrome of bit 549", exp_syn, {1'b1, 11'd550});
    scrub_en = 1'b1;
    for (i = 0; i < 1000 && !mem_we; i++) step(1);
    check(mem_we && mem_frame == 2 && mem_word == 17, "R5 write location",
          {mem_frame, mem_word}, {2'd2, 6'd17});
    check(mem_wdata == (mem_rdata ^ 32'h20), "R5 write data", mem_wdata, mem_rdata ^ 32'h20);
    wait_for_count(1, 1000);
    check(fixed_count == 1, "R6 repair confirmed", fixed_count, 1);
    check(err_frame == 2 && err_syndrome == exp_syn, "R7 error report",
          {err_frame, err_syndrome}, {2'd2, exp_syn});
    check(fmem[2][17] == good && !uncorrectable && we_cnt == 1,
          "R5 memory restored with one write", fmem[2][17], good);
    scrub_en = 1'b0;
    step(PASS_CYC);
  endtask

  task automatic t_edges();
    logic [31:0] g0, g1;
    do_reset();
    g0 = fmem[0][0];
    g1 = fmem[3][40];
    flip(0, 0, 0);
    flip(3, 40, 31);
    scrub_en = 1'b1;
    wait_for_count(2, 2000);
    check(fixed_count == 2, "R6 two edge repairs counted", fixed_count, 2);
    check(fmem[0][0] == g0 && fmem[3][40] == g1, "R5 first/last bit repaired",
          fmem[3][40], g1);
    check(err_frame == 3 && err_syndrome == {1'b1, 11'd1312}, "R7 last bit report",
          {err_frame, err_syndrome}, {2'd3, 1'b1, 11'd1312});
    check(!uncorrectable, "R5 no flag on correctable", uncorrectable, 0);
    scrub_en = 1'b0;
    step(PASS_CYC);
  endtask

  task automatic t_double();
    logic [11:0] exp_syn;
    logic [31:0] a, b;
    do_reset();
    flip(1, 3, 2);
    flip(1, 10, 7);
    a = fmem[1][3];
    b = fmem[1][10];
    exp_syn = calc_code(1) ^ fecc[1];
    scrub_en = 1'b1;
    wait_for_unc(1000);
    check(uncorrectable, "R8 double error flagged", uncorrectable, 1);
    check(err_frame == 1 && err_syndrome == exp_syn && exp_syn[11] == 1'b0,
          "R8 double error report", err_syndrome, exp_syn);
    step(2 * PASS_CYC);
    check(we_cnt == 0 && fixed_count == 0 && fmem[1][3] == a && fmem[1][10] == b,
          "R8 no write on double error", we_cnt, 0);
    check(uncorrectable, "R10 flag stays set", uncorrectable, 1);
    scrub_en = 1'b0;
    step(PASS_CYC);
  endtask

  task automatic t_bad_codes();
    do_reset();
    fecc[3] = fecc[3] ^ {1'b1, 11'd1500};
    scrub_en = 1'b1;
    wait_for_unc(1000);
    check(uncorrectable && err_frame == 3 && err_syndrome == {1'b1, 11'd1500},
          "R9 position beyond last bit", err_syndrome, {1'b1, 11'd1500});
    check(we_cnt == 0, "R9 no write beyond range", we_cnt, 0);
    do_reset();
    fecc[2] = fecc[2] ^ 12'h800;
    scrub_en = 1'b1;
    wait_for_unc(1000);
    check(uncorrectable && err_frame == 2 && err_syndrome == 12'h800,
          "R9 parity-only syndrome", err_syndrome, 12'h800);
    check(we_cnt == 0 && fixed_count == 0, "R9 no write on parity-only", we_cnt, 0);
    scrub_en = 1'b0;
    step(PASS_CYC);
  endtask

  task automatic t_stuck();
    do_reset();
    stuck = 1'b1;
    flip(1, 7, 3);
    scrub_en = 1'b1;
    wait_for_unc(1000);
    check(uncorrectable && fixed_count == 0, "R6 failed re-read flags error",
          {uncorrectable, fixed_count}, {1'b1, 16'd0});
    check(we_cnt >= 1 && err_frame == 1, "R6 write attempted before re-read", we_cnt, 1);
    scrub_en = 1'b0;
    step(PASS_CYC);
    stuck = 1'b0;
  endtask

  task automatic t_disable();
    logic [1:0]  fr;
    logic [31:0] bad;
    bit          ok;
    do_reset();
    scrub_en = 1'b1;
    step(60);
    scrub_en = 1'b0;
    step(100);
    flip(0, 5, 9);
    bad = fmem[0][5];
    fr  = mem_frame;
    ok  = 1'b1;
    for (int i = 0; i < 3 * PASS_CYC; i++) begin
      if (mem_frame != fr || mem_word != 0) ok = 1'b0;
      step(1);
    end
    check(ok, "R11 address held while idle", {mem_frame, mem_word}, {fr, 6'd0});
    check(we_cnt == 0 && fixed_count == 0 && fmem[0][5] == bad,
          "R11 error left alone while idle", fmem[0][5], bad);
    scrub_en = 1'b1;
    wait_for_count(1, 1000);
    check(fixed_count == 1 && err_frame == 0, "R11 scan resumes and repairs",
          fixed_count, 1);
    scrub_en = 1'b0;
    step(PASS_CYC);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks   = 0;
    fails    = 0;
    we_cnt   = 0;
    stuck    = 1'b0;
    scrub_en = 1'b0;
    rst_n    = 1'b0;
    t_reset();
    t_scan_order();
    t_single();
    t_edges();
    t_double();
    t_bad_codes();
    t_stuck();
    t_disable();
    finish_run();
  end
endmodule